// File: doc/BRIEF.md
# Backplane-to-PCI Address Translation Window

This block sits on the master side of a bridge between a backplane bus and PCI. It watches every backplane request. The upper half of the request address is compared against a programmed range, which is set by a lower bound and an upper bound. When the address falls inside that range and the window is enabled, the block accepts the request. It relocates the upper half of the address by a programmed offset, keeps the lower half unchanged, and issues a single PCI transaction.

If the PCI target answers with a retry, the block backs off for one cycle and then issues the same transaction again. It has no limit on the number of attempts and no give-up path. The backplane side reports busy for the whole time a transaction is outstanding. It sees a single-cycle acknowledge on the cycle the PCI target completes. On a read, the returned data appears on the backplane port in that same acknowledge cycle. Only one transaction is in flight at a time. Requests that miss the window are not accepted and produce no PCI activity.

Top module: `xlate_window`

## Requirements
- R1: After reset, `bpBusy`, `bpAck` and `pciReq` are all low.
- R2: A request presented while `bpBusy` is low, with the window enabled and `cfgLower <= bpAddr[31:16] <= cfgUpper` (both bounds inclusive), is accepted. `pciReq` is high in the following cycle.
- R3: A request whose `bpAddr[31:16]` lies below `cfgLower` or above `cfgUpper` is not accepted. In the following cycle `pciReq` and `bpBusy` stay low. This also covers the case where the lower bound is above the upper bound, which makes the window empty.
- R4: While `cfgEnable` is low, no address is accepted, whatever the bounds are.
- R5: For an accepted request, `pciAddr[31:16]` equals `bpAddr[31:16] - cfgLower + cfgOffset` taken modulo 2^16. `pciAddr[15:0]` equals `bpAddr[15:0]`.
- R6: For an accepted request, `pciWrite` equals the captured `bpWrite` (1 = write) and `pciWdata` equals the captured `bpWdata`.
- R7: A cycle with `pciReq` and `pciRetry` high and `pciDone` low is followed by exactly one cycle with `pciReq` low. After that, `pciReq` is high again with an unchanged `pciAddr`. This repeats for any number of retries.
- R8: `bpAck` is high for exactly the cycle in which `pciReq` and `pciDone` are both high. In that cycle `bpRdata` equals `pciRdata`. In the cycle after that, `pciReq` is low.
- R9: `bpBusy` is high from the cycle after acceptance through the acknowledge cycle. Backplane address changes during that time do not alter the outstanding `pciAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bpReq | input | 1 | Backplane request valid |
| bpWrite | input | 1 | Backplane direction, 1 = write |
| bpAddr | input | 32 | Backplane address |
| bpWdata | input | 32 | Backplane write data |
| bpBusy | output | 1 | A transaction is outstanding |
| bpAck | output | 1 | Completion acknowledge, one cycle |
| bpRdata | output | 32 | Read data, valid with bpAck |
| pciReq | output | 1 | PCI transaction request |
| pciWrite | output | 1 | PCI direction, 1 = write |
| pciAddr | output | 32 | Translated PCI address |
| pciWdata | output | 32 | PCI write data |
| pciDone | input | 1 | Target completed the transaction |
| pciRetry | input | 1 | Target asks for a retry |
| pciRdata | input | 32 | PCI read data |
| cfgEnable | input | 1 | Window enable |
| cfgLower | input | 16 | Lower bound of the address upper half |
| cfgUpper | input | 16 | Upper bound of the address upper half, inclusive |
| cfgOffset | input | 16 | Relocation offset for the upper half |

## Verification
The checks assume three things about the inputs. The configuration inputs stay constant while a transaction is outstanding. The target never raises `pciDone` and `pciRetry` in the same cycle. The target only answers while `pciReq` is high. The bench follows these rules: it changes bounds, offset and enable only between accesses, and it drives a single response at a time, only in a cycle when the request is visible. It sweeps every upper-half address from three below the lower bound to three above the upper bound for several windows, including an empty window, a window starting at zero and a relocation that wraps. It computes each expected PCI address arithmetically and varies the number of retries per access.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_BACKOFF = 2'd2
  } xlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request and translated address
    logic issue;     // PCI request visible
    logic complete;  // target finished this cycle
  } xlStrobe_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bpReq,
  input  logic      hit,
  input  logic      pciDone,
  input  logic      pciRetry,
  output xlStrobe_t strobe,
  output logic      bpBusy
);
  xlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strobe.capture  = 1'b0;
    strobe.issue    = 1'b0;
    strobe.complete = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (bpReq && hit) begin
          strobe.capture = 1'b1;
          stateNext      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strobe.issue = 1'b1;
        if (pciDone) begin
          strobe.complete = 1'b1;
          stateNext       = ST_IDLE;
        end else if (pciRetry) begin
          stateNext = ST_BACKOFF;
        end
      end
      ST_BACKOFF: stateNext = ST_ISSUE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  assign bpBusy = (state != ST_IDLE);
endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPLIT  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xlStrobe_t             strobe,
  input  logic                  bpWrite,
  input  logic [ADDR_W-1:0]     bpAddr,
  input  logic [DATA_W-1:0]     bpWdata,
  input  logic                  cfgEnable,
  input  logic [ADDR_W-SPLIT-1:0] cfgLower,
  input  logic [ADDR_W-SPLIT-1:0] cfgUpper,
  input  logic [ADDR_W-SPLIT-1:0] cfgOffset,
  input  logic [DATA_W-1:0]     pciRdata,
  output logic                  hit,
  output logic                  pciWrite,
  output logic [ADDR_W-1:0]     pciAddr,
  output logic [DATA_W-1:0]     pciWdata,
  output logic [DATA_W-1:0]     bpRdata
);
  localparam int HI_W = ADDR_W - SPLIT;

  logic [HI_W-1:0]  addrHi;
  logic [SPLIT-1:0] addrLo;
  logic [HI_W-1:0]  xlatHi;

  assign addrHi = bpAddr[ADDR_W-1:SPLIT];
  assign addrLo = bpAddr[SPLIT-1:0];

  // bounded compare on the upper half only; both bounds inclusive
  assign hit    = cfgEnable && (addrHi >= cfgLower) && (addrHi <= cfgUpper);
  // relocation wraps within the upper half
  assign xlatHi = addrHi - cfgLower + cfgOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pciAddr  <= '0;
      pciWdata <= '0;
      pciWrite <= 1'b0;
    end else if (strobe.capture) begin
      pciAddr  <= {xlatHi, addrLo};
      pciWdata <= bpWdata;
      pciWrite <= bpWrite;
    end
  end

  assign bpRdata = strobe.complete ? pciRdata : '0;
endmodule

// File: rtl/xlate_window.sv
module xlate_window
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPLIT  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bpReq,
  input  logic                    bpWrite,
  input  logic [ADDR_W-1:0]       bpAddr,
  input  logic [DATA_W-1:0]       bpWdata,
  output logic                    bpBusy,
  output logic                    bpAck,
  output logic [DATA_W-1:0]       bpRdata,
  output logic                    pciReq,
  output logic                    pciWrite,
  output logic [ADDR_W-1:0]       pciAddr,
  output logic [DATA_W-1:0]       pciWdata,
  input  logic                    pciDone,
  input  logic                    pciRetry,
  input  logic [DATA_W-1:0]       pciRdata,
  input  logic                    cfgEnable,
  input  logic [ADDR_W-SPLIT-1:0] cfgLower,
  input  logic [ADDR_W-SPLIT-1:0] cfgUpper,
  input  logic [ADDR_W-SPLIT-1:0] cfgOffset
);
  xlStrobe_t strobe;
  logic      hit;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bpReq(bpReq), .hit(hit),
    .pciDone(pciDone), .pciRetry(pciRetry),
    .strobe(strobe), .bpBusy(bpBusy)
  );

  xlate_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPLIT(SPLIT)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bpWrite(bpWrite), .bpAddr(bpAddr), .bpWdata(bpWdata),
    .cfgEnable(cfgEnable), .cfgLower(cfgLower), .cfgUpper(cfgUpper),
    .cfgOffset(cfgOffset), .pciRdata(pciRdata),
    .hit(hit), .pciWrite(pciWrite), .pciAddr(pciAddr),
    .pciWdata(pciWdata), .bpRdata(bpRdata)
  );

  assign pciReq = strobe.issue;
  assign bpAck  = strobe.complete;
endmodule

// File: rtl/xlate_window_chk.sv
module xlate_window_chk (
  input logic        clk,
  input logic        rstN,
  input logic        bpReq,
  input logic        bpBusy,
  input logic        bpAck,
  input logic [31:0] bpAddr,
  input logic [31:0] bpRdata,
  input logic        pciReq,
  input logic [31:0] pciAddr,
  input logic        pciDone,
  input logic        pciRetry,
  input logic [31:0] pciRdata,
  input logic        cfgEnable,
  input logic [15:0] cfgLower,
  input logic [15:0] cfgUpper,
  input logic [15:0] cfgOffset
);
  logic        inRange;
  logic [15:0] expHi;
  assign inRange = (bpAddr[31:16] >= cfgLower) && (bpAddr[31:16] <= cfgUpper);
  assign expHi   = bpAddr[31:16] - cfgLower + cfgOffset;

  // R2, R5: accepted request issues the relocated address next cycle
  a_r5_translate: assert property (@(posedge clk) disable iff (!rstN)
    (bpReq && !bpBusy && cfgEnable && inRange) |=>
      (pciReq && pciAddr == {$past(expHi), $past(bpAddr[15:0])}));

  // R3: out-of-range request causes no PCI activity
  a_r3_miss: assert property (@(posedge clk) disable iff (!rstN)
    (bpReq && !bpBusy && !inRange) |=> (!pciReq && !bpBusy));

  // R4: disabled window never accepts
  a_r4_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (bpReq && !bpBusy && !cfgEnable) |=> !pciReq);

  // R7: one idle cycle after a retry, then re-issue
  a_r7_backoff: assert property (@(posedge clk) disable iff (!rstN)
    (pciReq && pciRetry && !pciDone) |=> !pciReq ##1 pciReq);

  // R7, R9: outstanding address held until completion
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (pciReq && !pciDone) |=> $stable(pciAddr));

  // R8: ack coincides with completion and carries read data
  a_r8_ack: assert property (@(posedge clk) disable iff (!rstN)
    bpAck |-> (pciReq && pciDone && bpRdata == pciRdata));

  // R8: request dropped after completion
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    bpAck |=> !pciReq);

  // R9: PCI request only while busy
  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    pciReq |-> bpBusy);
endmodule

bind xlate_window xlate_window_chk u_chk (.*);

// File: tb/xlate_window_tb.sv
module xlate_window_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bpReq = 1'b0, bpWrite = 1'b0;
  logic [31:0] bpAddr = '0, bpWdata = '0;
  logic        bpBusy, bpAck, pciReq, pciWrite;
  logic [31:0] bpRdata, pciAddr, pciWdata;
  logic        pciDone = 1'b0, pciRetry = 1'b0;
  logic [31:0] pciRdata = '0;
  logic        cfgEnable = 1'b0;
  logic [15:0] cfgLower = '0, cfgUpper = '0, cfgOffset = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  xlate_window u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 100000);
      finish();
    end
  end

  // one backplane access; expectHit decides the checked path
  task automatic access(input logic [15:0] hi, input logic [15:0] lo,
                        input bit wr, input logic [31:0] wd, input int nRetry,
                        input logic [31:0] rd, input bit expectHit);
    logic [31:0] expAddr;
    expAddr = {16'(hi - cfgLower + cfgOffset), lo};
    @(negedge clk);
    bpReq = 1'b1; bpAddr = {hi, lo}; bpWrite = wr; bpWdata = wd;
    @(negedge clk);
    if (!expectHit) begin
      check(pciReq == 1'b0, "R3/R4 miss pciReq", {31'b0, pciReq}, 32'h0);
      check(bpBusy == 1'b0, "R3 miss bpBusy", {31'b0, bpBusy}, 32'h0);
      bpReq = 1'b0;
      @(negedge clk);
      check(pciReq == 1'b0, "R3/R4 miss later pciReq", {31'b0, pciReq}, 32'h0);
      return;
    end
    check(pciReq == 1'b1, "R2 hit pciReq", {31'b0, pciReq}, 32'h1);
    check(pciAddr == expAddr, "R5 pciAddr", pciAddr, expAddr);
    check(pciWrite == wr && pciWdata == wd, "R6 write fields", pciWdata, wd);
    check(bpBusy == 1'b1, "R9 busy", {31'b0, bpBusy}, 32'h1);
    // R9: a new address while busy must not disturb the outstanding one
    bpAddr = {cfgLower, ~lo};
    for (int k = 0; k < nRetry; k++) begin
      pciRetry = 1'b1;
      @(negedge clk);
      pciRetry = 1'b0;
      check(pciReq == 1'b0 && bpBusy == 1'b1, "R7 backoff", {31'b0, pciReq}, 32'h0);
      @(negedge clk);
      check(pciReq == 1'b1, "R7 reissue", {31'b0, pciReq}, 32'h1);
      check(pciAddr == expAddr, "R9 addr held", pciAddr, expAddr);
    end
    pciDone = 1'b1; pciRdata = rd; bpReq = 1'b0;
    #1;
    check(bpAck == 1'b1, "R8 ack", {31'b0, bpAck}, 32'h1);
    check(bpRdata == rd, "R8 rdata", bpRdata, rd);
    @(negedge clk);
    pciDone = 1'b0;
    check(pciReq == 1'b0 && bpAck == 1'b0, "R8 release", {31'b0, pciReq}, 32'h0);
    check(bpBusy == 1'b0, "R9 idle after ack", {31'b0, bpBusy}, 32'h0);
  endtask

  task automatic sweep(input logic [15:0] lo, input logic [15:0] up,
                       input logic [15:0] off, input bit en);
    int span;
    cfgLower = lo; cfgUpper = up; cfgOffset = off; cfgEnable = en;
    span = int'(up) - int'(lo);
    if (span < 0) span = 0;
    for (int h = -3; h <= span + 3; h++) begin
      int v;
      bit inWin;
      v = int'(lo) + h;
      if (v < 0 || v > 65535) continue;
      inWin = en && (v >= int'(lo)) && (v <= int'(up));
      access(16'(v), 16'(16'h1357 + h * 16'h0101), h[0], 32'hA5000000 + 32'(h),
             (h + 4) % 4, 32'hC0DE0000 ^ 32'(v), inWin);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bpBusy == 0 && bpAck == 0 && pciReq == 0, "R1 reset", {29'b0, bpBusy, bpAck, pciReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(bpBusy == 0 && pciReq == 0, "R1 after release", {30'b0, bpBusy, pciReq}, 32'h0);
    sweep(16'h0010, 16'h0014, 16'h8000, 1'b1);   // R2 R3 R5 ordinary window
    sweep(16'h0000, 16'h0002, 16'hFFFF, 1'b1);   // R5 window at zero, wrapping offset
    sweep(16'hFFFC, 16'hFFFF, 16'h0004, 1'b1);   // R5 top of space
    sweep(16'h0100, 16'h0100, 16'h1234, 1'b1);   // R2 single entry
    sweep(16'h0050, 16'h004F, 16'h0000, 1'b1);   // R3 empty window
    sweep(16'h0010, 16'h0014, 16'h8000, 1'b0);   // R4 disabled
    // R7: long retry run
    cfgLower = 16'h0200; cfgUpper = 16'h02FF; cfgOffset = 16'h4000; cfgEnable = 1'b1;
    access(16'h0234, 16'hBEEF, 1'b0, 32'h0, 12, 32'h12345678, 1'b1);
    finish();
  end
endmodule